// File: doc/BRIEF.md
# Memory protection region checker

This block checks every bus access against a bank of programmable protection regions. It returns the region's memory attributes and whether the access is allowed. Each region has a base address and a power-of-two size. It also has an enable bit, an eight-bit mask that can remove any of its eight equal subregions, a three-bit access-permission code, an execute-never bit, and the TEX, S, C and B memory-type bits. A synchronous write port loads one region per clock. The access port is purely combinational: an address, a write flag, a privileged flag and an instruction-fetch flag go in, and the result comes back in the same cycle.

When regions overlap, the matching region with the highest index supplies the attributes. A masked subregion does not count as a match, so a lower-priority region underneath can show through. A common example is a large region at the same base as a small one, with the large region's two lowest subregions masked. In that address range the small region's attributes apply.

Top module: `mpu_region_check`

## Requirements
- R1: After reset every region is disabled, so any access reports hit=0 and fault=1 until a region is written.
- R2: A region with size code n covers 2^(n+1) bytes starting at its base rounded down to that size. Size codes below 4 act as 4 (32 bytes), and codes above AW-1 act as AW-1.
- R3: A region of 256 bytes or more is split into eight equal subregions. Mask bit i removes subregion i, where bit 0 is the lowest address. An address in a removed subregion does not match that region. In regions smaller than 256 bytes the mask is ignored.
- R4: When several enabled regions match, the highest region index supplies every output attribute.
- R5: The memory type code is 0 for strongly ordered, 1 for device, 2 for normal and 3 for reserved. The cache code is 0 for none, 1 for write-through without write allocate, 2 for write-back without write allocate and 3 for write-back with read and write allocate. The {TEX,C,B} decode is:
  - 000,00: type 0, cache 0.
  - 000,01: type 1, cache 0.
  - 000,10: type 2, cache 1.
  - 000,11: type 2, cache 2.
  - 001,00: type 2, cache 0.
  - 001,11: type 2, cache 3.
  - 010,00: type 1, cache 0.
  - Every other {TEX,C,B} value: type 3, cache 0.
- R6: Shareability:
  - Normal memory: share = S.
  - Strongly ordered and {TEX,C,B}=000,01 device: share = 1.
  - {TEX,C,B}=010,00 device and reserved encodings: share = 0.
  - S has no effect outside normal memory.
- R7: Permission code AP decides which accesses are allowed (priv = privileged, user = unprivileged):
  - AP=0: no access.
  - AP=1: privileged read and write only.
  - AP=2: privileged read and write, user read.
  - AP=3: all read and write.
  - AP=4: reserved, always denied.
  - AP=5: privileged read only.
  - AP=6 and AP=7: read only for all.
  - A denied access sets fault.
- R8: An instruction fetch is checked as a read, whatever the write flag says. A fetch from a region with execute-never set always faults.
- R9: A miss forces fault=1, type=3, share=0 and cache=0. A hit with a reserved encoding also faults.
- R10: The result follows the access inputs in the same cycle. A region write takes effect at the clock edge, so an access in the same cycle as the write still sees the old region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load the selected region this cycle |
| cfg_idx | input | IW | Region index to load |
| cfg_base | input | AW | Region base address |
| cfg_size | input | SZW | Size code, size = 2^(code+1) bytes |
| cfg_en | input | 1 | Region enable |
| cfg_srd | input | 8 | Subregion removal mask |
| cfg_perm | input | 3 | Access-permission code |
| cfg_xn | input | 1 | Execute-never |
| cfg_tex | input | 3 | TEX memory-type bits |
| cfg_s | input | 1 | Shareable bit |
| cfg_c | input | 1 | C memory-type bit |
| cfg_b | input | 1 | B memory-type bit |
| acc_addr | input | AW | Access address |
| acc_write | input | 1 | Access is a write |
| acc_priv | input | 1 | Access is privileged |
| acc_fetch | input | 1 | Access is an instruction fetch |
| acc_hit | output | 1 | Some enabled region matches |
| acc_mtype | output | 2 | Memory type code |
| acc_share | output | 1 | Shareable |
| acc_cpol | output | 2 | Cache policy code |
| acc_fault | output | 1 | Permission, reserved or miss fault |

## Verification
A region load and an access to that same region can fall in the same cycle. The bench provokes this by driving a write that revokes a region's permission while it also drives a user read into that region. It samples the combinational result before the edge, where the old permission must still allow the read. It samples again after the edge, where the same read must fault. The random phase also mixes loads and accesses to overlapping regions, and it judges every result against a bench model that is updated only after each edge.

// File: rtl/mpurc_pkg.sv
package mpurc_pkg;
   typedef enum logic [1:0] {
      MT_STRONG = 2'd0,
      MT_DEVICE = 2'd1,
      MT_NORMAL = 2'd2,
      MT_RSVD   = 2'd3
   } mtype_e;

   typedef enum logic [1:0] {
      CP_NONE   = 2'd0,
      CP_WT_NA  = 2'd1,
      CP_WB_NA  = 2'd2,
      CP_WB_RWA = 2'd3
   } cpol_e;

   typedef struct packed {
      logic       en;
      logic [7:0] srd;
      logic [2:0] perm;
      logic       xn;
      logic [2:0] tex;
      logic       s;
      logic       c;
      logic       b;
   } rgn_attr_t;

   localparam int MIN_SIZE_CODE = 4;
   localparam int SUB_MIN_CODE  = 7;
endpackage

// File: rtl/mpurc_region_regs.sv
module mpurc_region_regs
   import mpurc_pkg::*;
#(
   parameter int NREG = 8,
   parameter int AW   = 32,
   parameter int SZW  = 5,
   parameter int IW   = 3
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           we,
   input  logic [IW-1:0]                  idx,
   input  logic [AW-1:0]                  base_in,
   input  logic [SZW-1:0]                 size_in,
   input  rgn_attr_t                      attr_in,
   output logic [NREG-1:0][AW-1:0]        base_q,
   output logic [NREG-1:0][SZW-1:0]       size_q,
   output rgn_attr_t [NREG-1:0]           attr_q
);
   logic [SZW-1:0] size_lim;

   always_comb begin
      if (int'(size_in) < MIN_SIZE_CODE)
         size_lim = SZW'(MIN_SIZE_CODE);
      else if (int'(size_in) > AW - 1)
         size_lim = SZW'(AW - 1);
      else
         size_lim = size_in;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         size_q <= '0;
         attr_q <= '0;
      end else if (we && (int'(idx) < NREG)) begin
         base_q[idx] <= base_in;
         size_q[idx] <= size_lim;
         attr_q[idx] <= attr_in;
      end
   end
endmodule

// File: rtl/mpurc_region_match.sv
module mpurc_region_match
   import mpurc_pkg::*;
#(
   parameter int AW  = 32,
   parameter int SZW = 5
) (
   input  logic [AW-1:0]  addr,
   input  logic [AW-1:0]  base,
   input  logic [SZW-1:0] size,
   input  logic           en,
   input  logic [7:0]     srd,
   output logic           hit
);
   logic [AW-1:0] span_mask;
   logic [AW-1:0] sub_shift;
   logic [2:0]    sub_idx;
   logic          in_span;
   logic          sub_off;

   always_comb begin
      span_mask = {AW{1'b1}} >> ((AW - 1) - int'(size));
      in_span   = ((addr ^ base) & ~span_mask) == '0;
      sub_shift = addr >> (int'(size) - 2);
      sub_idx   = sub_shift[2:0];
      sub_off   = (int'(size) >= SUB_MIN_CODE) && srd[sub_idx];
      hit       = en && in_span && !sub_off;
   end
endmodule

// File: rtl/mpurc_attr_decode.sv
module mpurc_attr_decode
   import mpurc_pkg::*;
(
   input  logic [2:0] tex,
   input  logic       s,
   input  logic       c,
   input  logic       b,
   output mtype_e     mtype,
   output logic       share,
   output cpol_e      cpol
);
   always_comb begin
      mtype = MT_RSVD;
      share = 1'b0;
      cpol  = CP_NONE;
      unique case ({tex, c, b})
         5'b000_00: begin mtype = MT_STRONG; share = 1'b1; end
         5'b000_01: begin mtype = MT_DEVICE; share = 1'b1; end
         5'b000_10: begin mtype = MT_NORMAL; share = s; cpol = CP_WT_NA;  end
         5'b000_11: begin mtype = MT_NORMAL; share = s; cpol = CP_WB_NA;  end
         5'b001_00: begin mtype = MT_NORMAL; share = s; end
         5'b001_11: begin mtype = MT_NORMAL; share = s; cpol = CP_WB_RWA; end
         5'b010_00: begin mtype = MT_DEVICE; end
         default:   begin mtype = MT_RSVD; end
      endcase
   end
endmodule

// File: rtl/mpurc_perm_check.sv
module mpurc_perm_check (
   input  logic [2:0] perm,
   input  logic       xn,
   input  logic       is_write,
   input  logic       is_priv,
   input  logic       is_fetch,
   output logic       allow
);
   logic [7:0] rd_priv, rd_user, wr_priv, wr_user;
   logic       eff_write;

   always_comb begin
      // bit k of each vector grants the access for permission code k
      rd_priv   = 8'b1110_1110;
      rd_user   = 8'b1100_1100;
      wr_priv   = 8'b0000_1110;
      wr_user   = 8'b0000_1000;
      eff_write = is_write && !is_fetch;
      if (is_fetch && xn)
         allow = 1'b0;
      else if (eff_write)
         allow = is_priv ? wr_priv[perm] : wr_user[perm];
      else
         allow = is_priv ? rd_priv[perm] : rd_user[perm];
   end
endmodule

// File: rtl/mpu_region_check.sv
module mpu_region_check
   import mpurc_pkg::*;
#(
   parameter int NREG = 8,
   parameter int AW   = 32,
   parameter int SZW  = $clog2(AW),
   parameter int IW   = (NREG > 1) ? $clog2(NREG) : 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           cfg_we,
   input  logic [IW-1:0]  cfg_idx,
   input  logic [AW-1:0]  cfg_base,
   input  logic [SZW-1:0] cfg_size,
   input  logic           cfg_en,
   input  logic [7:0]     cfg_srd,
   input  logic [2:0]     cfg_perm,
   input  logic           cfg_xn,
   input  logic [2:0]     cfg_tex,
   input  logic           cfg_s,
   input  logic           cfg_c,
   input  logic           cfg_b,
   input  logic [AW-1:0]  acc_addr,
   input  logic           acc_write,
   input  logic           acc_priv,
   input  logic           acc_fetch,
   output logic           acc_hit,
   output logic [1:0]     acc_mtype,
   output logic           acc_share,
   output logic [1:0]     acc_cpol,
   output logic           acc_fault
);
   if (NREG < 1 || NREG > 16) begin : g_bad_nreg
      $error("mpu_region_check: NREG must be 1..16");
   end
   if (AW < 16 || AW > 64) begin : g_bad_aw
      $error("mpu_region_check: AW must be 16..64");
   end
   if ((1 << SZW) < AW) begin : g_bad_szw
      $error("mpu_region_check: SZW too narrow for AW");
   end

   rgn_attr_t                 cfg_attr;
   logic [NREG-1:0][AW-1:0]   base_q;
   logic [NREG-1:0][SZW-1:0]  size_q;
   rgn_attr_t [NREG-1:0]      attr_q;
   logic [NREG-1:0]           hits;
   logic [IW-1:0]             sel;
   logic                      any_hit;
   rgn_attr_t                 sel_attr;
   mtype_e                    dec_mtype;
   logic                      dec_share;
   cpol_e                     dec_cpol;
   logic                      perm_ok;

   assign cfg_attr = '{en: cfg_en, srd: cfg_srd, perm: cfg_perm, xn: cfg_xn,
                       tex: cfg_tex, s: cfg_s, c: cfg_c, b: cfg_b};

   mpurc_region_regs #(.NREG(NREG), .AW(AW), .SZW(SZW), .IW(IW)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (cfg_we),
      .idx     (cfg_idx),
      .base_in (cfg_base),
      .size_in (cfg_size),
      .attr_in (cfg_attr),
      .base_q  (base_q),
      .size_q  (size_q),
      .attr_q  (attr_q)
   );

   for (genvar g = 0; g < NREG; g++) begin : g_rgn
      mpurc_region_match #(.AW(AW), .SZW(SZW)) u_match (
         .addr (acc_addr),
         .base (base_q[g]),
         .size (size_q[g]),
         .en   (attr_q[g].en),
         .srd  (attr_q[g].srd),
         .hit  (hits[g])
      );
   end

   if (NREG == 1) begin : g_single
      assign sel     = '0;
      assign any_hit = hits[0];
   end else begin : g_multi
      always_comb begin
         sel     = '0;
         any_hit = 1'b0;
         for (int i = 0; i < NREG; i++) begin
            if (hits[i]) begin
               sel     = IW'(i);
               any_hit = 1'b1;
            end
         end
      end
   end

   assign sel_attr = attr_q[sel];

   mpurc_attr_decode u_dec (
      .tex   (sel_attr.tex),
      .s     (sel_attr.s),
      .c     (sel_attr.c),
      .b     (sel_attr.b),
      .mtype (dec_mtype),
      .share (dec_share),
      .cpol  (dec_cpol)
   );

   mpurc_perm_check u_perm (
      .perm     (sel_attr.perm),
      .xn       (sel_attr.xn),
      .is_write (acc_write),
      .is_priv  (acc_priv),
      .is_fetch (acc_fetch),
      .allow    (perm_ok)
   );

   always_comb begin
      acc_hit   = any_hit;
      acc_mtype = any_hit ? dec_mtype : MT_RSVD;
      acc_share = any_hit && dec_share;
      acc_cpol  = any_hit ? dec_cpol : CP_NONE;
      acc_fault = !any_hit || (dec_mtype == MT_RSVD) || !perm_ok;
   end
endmodule

// File: rtl/mpurc_sva.sv
module mpurc_sva (
   input logic       clk,
   input logic       rst_n,
   input logic       acc_hit,
   input logic [1:0] acc_mtype,
   input logic       acc_share,
   input logic [1:0] acc_cpol,
   input logic       acc_fault
);
   p_reset_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !acc_hit);

   p_miss_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_hit |-> (acc_fault && acc_mtype == 2'd3 && !acc_share && acc_cpol == 2'd0));

   p_rsvd_faults_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_mtype == 2'd3) |-> acc_fault);

   p_cache_only_normal_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_mtype != 2'd2) |-> (acc_cpol == 2'd0));

   p_strong_shared_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_mtype == 2'd0) |-> acc_share);
endmodule

bind mpu_region_check mpurc_sva u_sva (
   .clk       (clk),
   .rst_n     (rst_n),
   .acc_hit   (acc_hit),
   .acc_mtype (acc_mtype),
   .acc_share (acc_share),
   .acc_cpol  (acc_cpol),
   .acc_fault (acc_fault)
);

// File: tb/mpu_region_check_test.sv
module mpu_region_check_test;
   localparam int NREG = 8;
   localparam int AW   = 32;
   localparam int SZW  = 5;
   localparam int IW   = 3;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           cfg_we = 1'b0;
   logic [IW-1:0]  cfg_idx = '0;
   logic [AW-1:0]  cfg_base = '0;
   logic [SZW-1:0] cfg_size = '0;
   logic           cfg_en = 1'b0;
   logic [7:0]     cfg_srd = '0;
   logic [2:0]     cfg_perm = '0;
   logic           cfg_xn = 1'b0;
   logic [2:0]     cfg_tex = '0;
   logic           cfg_s = 1'b0, cfg_c = 1'b0, cfg_b = 1'b0;
   logic [AW-1:0]  acc_addr = '0;
   logic           acc_write = 1'b0, acc_priv = 1'b0, acc_fetch = 1'b0;
   logic           acc_hit, acc_share, acc_fault;
   logic [1:0]     acc_mtype, acc_cpol;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   // bench model of the programmed regions
   logic [31:0] m_base [NREG];
   int          m_sz   [NREG];
   bit          m_en   [NREG];
   logic [7:0]  m_srd  [NREG];
   logic [2:0]  m_perm [NREG];
   bit          m_xn   [NREG];
   logic [2:0]  m_tex  [NREG];
   bit          m_s [NREG], m_c [NREG], m_b [NREG];

   mpu_region_check #(.NREG(NREG), .AW(AW)) uut (.*);

   always #10 clk = ~clk;

   function automatic bit in_region(int r, logic [31:0] a);
      longint unsigned sz, start, part, sub;
      if (!m_en[r]) return 1'b0;
      sz    = 64'd1 << (m_sz[r] + 1);
      start = longint'(m_base[r]) & ~(sz - 1);
      if (longint'(a) < start || longint'(a) >= start + sz) return 1'b0;
      if (sz < 256) return 1'b1;
      part = sz / 8;
      sub  = (longint'(a) - start) / part;
      return !m_srd[r][sub];
   endfunction

   function automatic bit perm_allows(logic [2:0] ap, bit xn, bit wr, bit pr, bit fe);
      if (fe) begin
         if (xn) return 1'b0;
         wr = 1'b0;
      end
      case (ap)
         3'd0, 3'd4: return 1'b0;
         3'd1: return pr;
         3'd2: return pr || !wr;
         3'd3: return 1'b1;
         3'd5: return pr && !wr;
         default: return !wr;
      endcase
   endfunction

   // returns {hit, mtype[1:0], share, cpol[1:0], fault}
   function automatic logic [6:0] expect_out(logic [31:0] a, bit wr, bit pr, bit fe);
      int r = -1;
      logic [1:0] mt, cp;
      bit sh, ok;
      for (int i = 0; i < NREG; i++) if (in_region(i, a)) r = i;
      if (r < 0) return {1'b0, 2'd3, 1'b0, 2'd0, 1'b1};
      mt = 2'd3; sh = 1'b0; cp = 2'd0;
      case ({m_tex[r], m_c[r], m_b[r]})
         5'b00000: begin mt = 2'd0; sh = 1'b1; end
         5'b00001: begin mt = 2'd1; sh = 1'b1; end
         5'b00010: begin mt = 2'd2; sh = m_s[r]; cp = 2'd1; end
         5'b00011: begin mt = 2'd2; sh = m_s[r]; cp = 2'd2; end
         5'b00100: begin mt = 2'd2; sh = m_s[r]; end
         5'b00111: begin mt = 2'd2; sh = m_s[r]; cp = 2'd3; end
         5'b01000: begin mt = 2'd1; end
         default: ;
      endcase
      ok = perm_allows(m_perm[r], m_xn[r], wr, pr, fe);
      return {1'b1, mt, sh, cp, (mt == 2'd3) || !ok};
   endfunction

   task automatic model_write(int idx, logic [31:0] base, int sz, bit en, logic [7:0] srd,
                              logic [2:0] ap, bit xn, logic [2:0] tex, bit s, bit c, bit b);
      m_base[idx] = base;
      m_sz[idx]   = (sz < 4) ? 4 : sz;
      m_en[idx]   = en;   m_srd[idx] = srd; m_perm[idx] = ap; m_xn[idx] = xn;
      m_tex[idx]  = tex;  m_s[idx] = s; m_c[idx] = c; m_b[idx] = b;
   endtask

   task automatic drive_cfg(int idx, logic [31:0] base, int sz, bit en, logic [7:0] srd,
                            logic [2:0] ap, bit xn, logic [2:0] tex, bit s, bit c, bit b);
      cfg_idx = IW'(idx); cfg_base = base; cfg_size = SZW'(sz); cfg_en = en;
      cfg_srd = srd; cfg_perm = ap; cfg_xn = xn; cfg_tex = tex;
      cfg_s = s; cfg_c = c; cfg_b = b;
   endtask

   task automatic write_region(int idx, logic [31:0] base, int sz, bit en, logic [7:0] srd,
                               logic [2:0] ap, bit xn, logic [2:0] tex, bit s, bit c, bit b);
      @(negedge clk);
      drive_cfg(idx, base, sz, en, srd, ap, xn, tex, s, c, b);
      cfg_we = 1'b1;
      @(posedge clk);
      #1 cfg_we = 1'b0;
      model_write(idx, base, sz, en, srd, ap, xn, tex, s, c, b);
   endtask

   task automatic compare(string req, logic [31:0] a, logic [6:0] exp_v);
      logic [6:0] act;
      act = {acc_hit, acc_mtype, acc_share, acc_cpol, acc_fault};
      total++;
      if (act !== exp_v) begin
         bad++;
         $display("FAIL %s addr=%h actual=%b expected=%b", req, a, act, exp_v);
      end
   endtask

   task automatic check_access(string req, logic [31:0] a, bit wr, bit pr, bit fe);
      @(negedge clk);
      acc_addr = a; acc_write = wr; acc_priv = pr; acc_fetch = fe;
      #2 compare(req, a, expect_out(a, wr, pr, fe));
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      for (int i = 0; i < NREG; i++) model_write(i, 0, 4, 0, 0, 0, 0, 0, 0, 0, 0);
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: empty after reset
      check_access("R1", 32'h0000_1234, 0, 1, 0);
      check_access("R1", 32'h0000_0000, 1, 0, 0);

      // R2: span and alignment (unaligned base rounds down), 4 KB region
      write_region(2, 32'h0000_4100, 11, 1, 8'h00, 3'd3, 0, 3'b000, 0, 1, 1);
      check_access("R2", 32'h0000_4000, 0, 1, 0);
      check_access("R2", 32'h0000_4FFF, 1, 0, 0);
      check_access("R2", 32'h0000_5000, 0, 1, 0);
      check_access("R2", 32'h0000_3FFF, 0, 1, 0);
      // R2: size code below 4 behaves as 32 bytes
      write_region(4, 32'h0000_8000, 2, 1, 8'h00, 3'd3, 0, 3'b000, 0, 0, 1);
      check_access("R2", 32'h0000_801F, 0, 1, 0);
      check_access("R2", 32'h0000_8020, 0, 1, 0);

      // R3: large region over small at same base, two lowest subregions removed
      write_region(0, 32'h0000_0000, 16, 1, 8'h00, 3'd3, 0, 3'b001, 1, 0, 0);
      write_region(1, 32'h0000_0000, 18, 1, 8'h03, 3'd3, 0, 3'b000, 0, 0, 1);
      check_access("R3", 32'h0001_0000, 0, 1, 0);
      check_access("R3", 32'h0001_FFFF, 0, 0, 0);
      check_access("R3", 32'h0002_0000, 0, 1, 0);
      check_access("R3", 32'h0007_FFFF, 1, 1, 0);
      // R4: region 2 lies inside both and wins
      check_access("R4", 32'h0000_4800, 0, 1, 0);
      // R3: mask ignored below 256 bytes, applied at 256 bytes
      write_region(5, 32'h0009_0000, 6, 1, 8'hFF, 3'd3, 0, 3'b000, 0, 1, 0);
      check_access("R3", 32'h0009_0010, 0, 1, 0);
      write_region(6, 32'h000A_0000, 7, 1, 8'h01, 3'd3, 0, 3'b000, 0, 1, 0);
      check_access("R3", 32'h000A_0000, 0, 1, 0);
      check_access("R3", 32'h000A_0020, 0, 1, 0);

      // R7 / R8: every permission code with every access kind and execute-never
      for (int ap = 0; ap < 8; ap++) begin
         for (int xn = 0; xn < 2; xn++) begin
            write_region(7, 32'h000B_0000, 11, 1, 8'h00, 3'(ap), xn[0], 3'b000, 0, 1, 1);
            for (int k = 0; k < 8; k++)
               check_access((k[2] || xn[0]) ? "R8" : "R7", 32'h000B_0100, k[0], k[1], k[2]);
         end
      end

      // R5 / R6: every TEX, C, B, S combination
      for (int t = 0; t < 8; t++)
         for (int cb = 0; cb < 4; cb++)
            for (int s = 0; s < 2; s++) begin
               write_region(7, 32'h000B_0000, 11, 1, 8'h00, 3'd3, 0, 3'(t), s[0], cb[1], cb[0]);
               check_access(s[0] ? "R6" : "R5", 32'h000B_0200, 0, 1, 0);
            end

      // R10: write and access in the same cycle
      write_region(7, 32'h000B_0000, 11, 1, 8'h00, 3'd3, 0, 3'b000, 0, 1, 1);
      @(negedge clk);
      drive_cfg(7, 32'h000B_0000, 11, 1, 8'h00, 3'd0, 0, 3'b000, 0, 1, 1);
      cfg_we = 1'b1;
      acc_addr = 32'h000B_0040; acc_write = 1'b0; acc_priv = 1'b0; acc_fetch = 1'b0;
      #2 compare("R10", acc_addr, {1'b1, 2'd2, 1'b0, 2'd2, 1'b0});
      @(posedge clk);
      #1 cfg_we = 1'b0;
      model_write(7, 32'h000B_0000, 11, 1, 8'h00, 3'd0, 0, 3'b000, 0, 1, 1);
      #1 compare("R10", acc_addr, {1'b1, 2'd2, 1'b0, 2'd2, 1'b1});

      // random mix, R4 priority among overlapping regions
      for (int it = 0; it < 400; it++) begin
         write_region($urandom_range(7, 0), 32'($urandom_range(32'hFFFFF, 0)),
                      $urandom_range(19, 2), ($urandom_range(3, 0) != 0),
                      8'($urandom), 3'($urandom), 1'($urandom), 3'($urandom_range(2, 0)),
                      1'($urandom), 1'($urandom), 1'($urandom));
         for (int k = 0; k < 4; k++)
            check_access("R4", 32'($urandom_range(32'hFFFFF, 0)),
                         1'($urandom), 1'($urandom), 1'($urandom));
      end

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule